// File: doc/BRIEF.md
# Paired-Page Translation Buffer with Per-Entry Page Size

This block is a small, fully associative translation buffer for a memory management unit of the classic load/store processor kind. Each entry maps two neighbouring virtual pages, an even one and an odd one, onto two independent physical frames. Each entry also carries its own page size, from 4 KiB up to 16 MiB in steps of four. The size sets how many virtual page number bits take part in the comparison. It also sets which address bit picks the even or odd half.

Software loads entries through an indexed write port. A probe port searches the buffer for a given page, address space tag and region, and reports where the page sits. The translate port takes a 64-bit virtual address, the current address space tag and a store flag. One cycle later it returns one of two results. The first is a physical address with a cacheability attribute. The second is one of four fault codes, and in that case the faulting address is held in a bad-address register. A mode input selects 64-bit addressing. In that mode the region field and the unimplemented address bits are checked as well.

Top module: `pair_tlb`

## Requirements
- R1: Reset clears every entry field to zero, including both valid bits, and all output registers to zero. After reset, a translation whose page number is not zero reports a refill (code 1), and a probe of such a page returns 0.
- R2: A written mask field (the page mask with bits below 13 dropped) equal to 2^(2s)-1, for s from 0 to 6, selects a page of 4 KiB·4^s. Any other value raises `wrMaskBad` in the write cycle, and the entry then behaves as a 4 KiB entry.
- R3: An entry of size code s compares only virtual address bits [VA_BITS-1 : 13+2s] with its stored page number. Address bit 12+2s chooses the odd half (1) or the even half (0).
- R4: An entry with its global bit set matches under any address space tag. Any other entry matches only when its stored tag equals `xlAsid` (or `prAsid` for a probe).
- R5: When no entry matches, translation reports refill (code 1). In 64-bit mode (`mode64`=1), address bits [63:62] must also equal the entry's region. With `mode64`=0 the region is ignored.
- R6: When an entry matches but the chosen half has its valid bit clear, translation reports invalid (code 2).
- R7: When the chosen half is valid, the access is a store and its dirty bit is clear, translation reports modify (code 3).
- R8: Otherwise translation reports code 0. The result is the physical address formed from the frame number shifted left by 12, with its low 12+2s bits replaced by the same virtual address bits. `xlUncached` equals the half's uncached bit. On a fault, `xlPa` and `xlUncached` are 0.
- R9: Every translation fault (any nonzero code) loads the full virtual address into `badVaddr`. A fault-free translation leaves it unchanged.
- R10: In 64-bit mode, an address with any bit in [61:VA_BITS] set reports address error (code 4). This takes priority over every buffer result. With `mode64`=0 these bits are not checked.
- R11: A probe returns the matching entry index plus one in `prResult`, and 0 when nothing matches. The result is registered, and `prDone` is high for one cycle.
- R12: When several entries match, the lowest index supplies the result of both probe and translation. `xlMulti` is raised in that case, and it is 0 for a single match, for no match and for an address error.
- R13: The result of a translation request held in cycle n shows on the outputs from cycle n+1, with `xlDone` high for exactly those cycles that follow a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| mode64 | input | 1 | 1: 64-bit addressing, region and range checks enabled |
| wrEn | input | 1 | Write the entry at `wrIdx` |
| wrIdx | input | IDX_W | Entry index to write |
| wrMaskField | input | 12 | Page mask bits 24:13 |
| wrVpn2 | input | VA_BITS-13 | Paired page number (address bits VA_BITS-1:13) |
| wrRegion | input | 2 | Region (address bits 63:62) |
| wrAsid | input | ASID_W | Address space tag |
| wrGlobal | input | 1 | Match under any tag |
| wrPfn0 | input | PA_BITS-12 | Even-half frame number |
| wrValid0 | input | 1 | Even-half valid |
| wrDirty0 | input | 1 | Even-half writable |
| wrUncached0 | input | 1 | Even-half uncached |
| wrPfn1 | input | PA_BITS-12 | Odd-half frame number |
| wrValid1 | input | 1 | Odd-half valid |
| wrDirty1 | input | 1 | Odd-half writable |
| wrUncached1 | input | 1 | Odd-half uncached |
| wrMaskBad | output | 1 | Written mask field is not a legal size |
| prEn | input | 1 | Probe request |
| prVpn2 | input | VA_BITS-13 | Probe paired page number |
| prRegion | input | 2 | Probe region |
| prAsid | input | ASID_W | Probe tag |
| prDone | output | 1 | Probe result valid |
| prResult | output | PRB_W | Matching index plus one, 0 on miss |
| xlEn | input | 1 | Translation request |
| xlVa | input | 64 | Virtual address |
| xlAsid | input | ASID_W | Current address space tag |
| xlStore | input | 1 | 1 for a store |
| xlDone | output | 1 | Translation result valid |
| xlExc | output | 3 | 0 ok, 1 refill, 2 invalid, 3 modify, 4 address error |
| xlPa | output | PA_BITS | Physical address |
| xlUncached | output | 1 | Access is uncached |
| xlMulti | output | 1 | More than one entry matched |
| badVaddr | output | 64 | Last faulting virtual address |

## Verification
The bench builds the block with its defaults: 8 entries, 40 implemented virtual bits, 36 physical bits and 8-bit tags. Eight entries are enough to hold every one of the seven page sizes together with a deliberately duplicated entry, so size masking, half selection and lowest-index priority can all be reached in one load. Forty virtual bits leave a 22-bit gap below the region field, which lets address-error cases be placed well clear of the largest page.

// File: rtl/pair_tlb_pkg.sv
package pair_tlb_pkg;

  typedef enum logic [2:0] {
    EXC_NONE    = 3'd0,
    EXC_REFILL  = 3'd1,
    EXC_INVALID = 3'd2,
    EXC_MODIFY  = 3'd3,
    EXC_ADDR    = 3'd4
  } excCode_t;

  typedef struct packed {
    logic     load;
    logic     latchBad;
    excCode_t exc;
  } xlStrb_t;

  localparam int NUM_SIZES = 7;

  // returns {bad, sizeCode}
  function automatic logic [3:0] decodeMask(input logic [11:0] field);
    for (int s = 0; s < NUM_SIZES; s++) begin
      if (field == 12'((1 << (2 * s)) - 1)) return {1'b0, 3'(s)};
    end
    return 4'b1000;
  endfunction

endpackage

// File: rtl/pair_tlb_ctrl.sv
module pair_tlb_ctrl
  import pair_tlb_pkg::*;
(
  input  logic    xlEn,
  input  logic    xlStore,
  input  logic    addrErr,
  input  logic    anyHit,
  input  logic    selValid,
  input  logic    selDirty,
  output xlStrb_t strb
);

  always_comb begin
    strb.load = xlEn;
    if (addrErr)                    strb.exc = EXC_ADDR;
    else if (!anyHit)               strb.exc = EXC_REFILL;
    else if (!selValid)             strb.exc = EXC_INVALID;
    else if (xlStore && !selDirty)  strb.exc = EXC_MODIFY;
    else                            strb.exc = EXC_NONE;
    strb.latchBad = xlEn && (strb.exc != EXC_NONE);
  end

endmodule

// File: rtl/pair_tlb_dp.sv
module pair_tlb_dp
  import pair_tlb_pkg::*;
#(
  parameter int NUM_ENTRIES = 8,
  parameter int VA_BITS     = 40,
  parameter int PA_BITS     = 36,
  parameter int ASID_W      = 8,
  localparam int IDX_W  = $clog2(NUM_ENTRIES),
  localparam int PRB_W  = $clog2(NUM_ENTRIES + 1),
  localparam int VPN2_W = VA_BITS - 13,
  localparam int PFN_W  = PA_BITS - 12
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              mode64,
  input  logic              wrEn,
  input  logic [IDX_W-1:0]  wrIdx,
  input  logic [11:0]       wrMaskField,
  input  logic [VPN2_W-1:0] wrVpn2,
  input  logic [1:0]        wrRegion,
  input  logic [ASID_W-1:0] wrAsid,
  input  logic              wrGlobal,
  input  logic [PFN_W-1:0]  wrPfn0,
  input  logic [2:0]        wrBits0,
  input  logic [PFN_W-1:0]  wrPfn1,
  input  logic [2:0]        wrBits1,
  output logic              wrMaskBad,
  input  logic              prEn,
  input  logic [VPN2_W-1:0] prVpn2,
  input  logic [1:0]        prRegion,
  input  logic [ASID_W-1:0] prAsid,
  output logic              prDone,
  output logic [PRB_W-1:0]  prResult,
  input  logic              xlEn,
  input  logic [63:0]       xlVa,
  input  logic [ASID_W-1:0] xlAsid,
  input  logic              xlStore,
  input  xlStrb_t           strb,
  output logic              addrErr,
  output logic              anyHit,
  output logic              selValid,
  output logic              selDirty,
  output logic              xlDone,
  output logic [2:0]        xlExc,
  output logic [PA_BITS-1:0] xlPa,
  output logic              xlUncached,
  output logic              xlMulti,
  output logic [63:0]       badVaddr
);

  // entry storage; halves indexed 0 even, 1 odd; bits {uncached, dirty, valid}
  logic [2:0]        szQ   [NUM_ENTRIES];
  logic [VPN2_W-1:0] vpnQ  [NUM_ENTRIES];
  logic [1:0]        rgnQ  [NUM_ENTRIES];
  logic [ASID_W-1:0] asidQ [NUM_ENTRIES];
  logic              gQ    [NUM_ENTRIES];
  logic [PFN_W-1:0]  pfnQ  [NUM_ENTRIES][2];
  logic [2:0]        bitsQ [NUM_ENTRIES][2];

  logic [3:0] maskDec;
  assign maskDec   = decodeMask(wrMaskField);
  assign wrMaskBad = wrEn && maskDec[3];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_ENTRIES; i++) begin
        szQ[i] <= '0; vpnQ[i] <= '0; rgnQ[i] <= '0; asidQ[i] <= '0; gQ[i] <= 1'b0;
        for (int h = 0; h < 2; h++) begin
          pfnQ[i][h]  <= '0;
          bitsQ[i][h] <= '0;
        end
      end
    end else if (wrEn) begin
      szQ[wrIdx]      <= maskDec[2:0];
      vpnQ[wrIdx]     <= wrVpn2;
      rgnQ[wrIdx]     <= wrRegion;
      asidQ[wrIdx]    <= wrAsid;
      gQ[wrIdx]       <= wrGlobal;
      pfnQ[wrIdx][0]  <= wrPfn0;
      pfnQ[wrIdx][1]  <= wrPfn1;
      bitsQ[wrIdx][0] <= wrBits0;
      bitsQ[wrIdx][1] <= wrBits1;
    end
  end

  // per-entry match, shared structure for translate and probe
  logic [NUM_ENTRIES-1:0] xlHit, prHit;
  for (genvar i = 0; i < NUM_ENTRIES; i++) begin : gMatch
    logic [VPN2_W-1:0] keep;
    assign keep = {VPN2_W{1'b1}} << {szQ[i], 1'b0};
    assign xlHit[i] = (((xlVa[VA_BITS-1:13] ^ vpnQ[i]) & keep) == '0)
                      && (gQ[i] || (asidQ[i] == xlAsid))
                      && (!mode64 || (rgnQ[i] == xlVa[63:62]));
    assign prHit[i] = (((prVpn2 ^ vpnQ[i]) & keep) == '0)
                      && (gQ[i] || (asidQ[i] == prAsid))
                      && (!mode64 || (rgnQ[i] == prRegion));
  end

  logic [IDX_W-1:0] xlIdx, prIdx;
  always_comb begin
    xlIdx = '0;
    prIdx = '0;
    for (int i = NUM_ENTRIES - 1; i >= 0; i--) begin
      if (xlHit[i]) xlIdx = IDX_W'(i);
      if (prHit[i]) prIdx = IDX_W'(i);
    end
  end

  logic              multiHit;
  logic [5:0]        pageBits;
  logic              oddSel;
  logic [PFN_W-1:0]  selPfn;
  logic [PA_BITS-1:0] offMask, paNext;
  logic [2:0]        selBits;

  assign anyHit   = xlHit != '0;
  assign multiHit = (xlHit & (xlHit - 1'b1)) != '0;
  assign addrErr  = mode64 && (xlVa[61:VA_BITS] != '0);
  assign pageBits = 6'd12 + {2'b00, szQ[xlIdx], 1'b0};
  assign oddSel   = xlVa[pageBits];
  assign selPfn   = pfnQ[xlIdx][oddSel];
  assign selBits  = bitsQ[xlIdx][oddSel];
  assign selValid = selBits[0];
  assign selDirty = selBits[1];
  assign offMask  = ~({PA_BITS{1'b1}} << pageBits);
  assign paNext   = ({selPfn, 12'h000} & ~offMask) | (xlVa[PA_BITS-1:0] & offMask);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      xlDone <= 1'b0; xlExc <= '0; xlPa <= '0; xlUncached <= 1'b0;
      xlMulti <= 1'b0; badVaddr <= '0; prDone <= 1'b0; prResult <= '0;
    end else begin
      xlDone <= strb.load;
      if (strb.load) begin
        xlExc      <= strb.exc;
        xlPa       <= (strb.exc == EXC_NONE) ? paNext : '0;
        xlUncached <= (strb.exc == EXC_NONE) && selBits[2];
        xlMulti    <= !addrErr && multiHit;
      end
      if (strb.latchBad) badVaddr <= xlVa;
      prDone <= prEn;
      if (prEn) prResult <= (prHit != '0) ? PRB_W'(prIdx) + PRB_W'(1) : '0;
    end
  end

  AST_DONE_NEXT: assert property (@(posedge clk) disable iff (!rstN)
    xlEn |=> xlDone);                                                  // R13
  AST_BAD_ON_FAULT: assert property (@(posedge clk) disable iff (!rstN)
    (xlDone && xlExc != 3'd0) |-> badVaddr == $past(xlVa));            // R9
  AST_MODIFY_IS_STORE: assert property (@(posedge clk) disable iff (!rstN)
    (xlDone && xlExc == 3'd3) |-> $past(xlStore));                     // R7
  AST_MULTI_HAS_HIT: assert property (@(posedge clk) disable iff (!rstN)
    xlMulti |-> (xlExc != 3'd1 && xlExc != 3'd4));                     // R12
  AST_PROBE_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    prDone |-> prResult <= PRB_W'(NUM_ENTRIES));                       // R11
  AST_FAULT_NO_PA: assert property (@(posedge clk) disable iff (!rstN)
    (xlDone && xlExc != 3'd0) |-> (xlPa == '0 && !xlUncached));        // R8

endmodule

// File: rtl/pair_tlb.sv
module pair_tlb
  import pair_tlb_pkg::*;
#(
  parameter int NUM_ENTRIES = 8,
  parameter int VA_BITS     = 40,
  parameter int PA_BITS     = 36,
  parameter int ASID_W      = 8,
  localparam int IDX_W  = $clog2(NUM_ENTRIES),
  localparam int PRB_W  = $clog2(NUM_ENTRIES + 1),
  localparam int VPN2_W = VA_BITS - 13,
  localparam int PFN_W  = PA_BITS - 12
)(
  input  logic               clk,
  input  logic               rstN,
  input  logic               mode64,
  input  logic               wrEn,
  input  logic [IDX_W-1:0]   wrIdx,
  input  logic [11:0]        wrMaskField,
  input  logic [VPN2_W-1:0]  wrVpn2,
  input  logic [1:0]         wrRegion,
  input  logic [ASID_W-1:0]  wrAsid,
  input  logic               wrGlobal,
  input  logic [PFN_W-1:0]   wrPfn0,
  input  logic               wrValid0,
  input  logic               wrDirty0,
  input  logic               wrUncached0,
  input  logic [PFN_W-1:0]   wrPfn1,
  input  logic               wrValid1,
  input  logic               wrDirty1,
  input  logic               wrUncached1,
  output logic               wrMaskBad,
  input  logic               prEn,
  input  logic [VPN2_W-1:0]  prVpn2,
  input  logic [1:0]         prRegion,
  input  logic [ASID_W-1:0]  prAsid,
  output logic               prDone,
  output logic [PRB_W-1:0]   prResult,
  input  logic               xlEn,
  input  logic [63:0]        xlVa,
  input  logic [ASID_W-1:0]  xlAsid,
  input  logic               xlStore,
  output logic               xlDone,
  output logic [2:0]         xlExc,
  output logic [PA_BITS-1:0] xlPa,
  output logic               xlUncached,
  output logic               xlMulti,
  output logic [63:0]        badVaddr
);

  xlStrb_t strb;
  logic addrErr, anyHit, selValid, selDirty;

  pair_tlb_ctrl u_ctrl (
    .xlEn(xlEn), .xlStore(xlStore), .addrErr(addrErr), .anyHit(anyHit),
    .selValid(selValid), .selDirty(selDirty), .strb(strb)
  );

  pair_tlb_dp #(
    .NUM_ENTRIES(NUM_ENTRIES), .VA_BITS(VA_BITS), .PA_BITS(PA_BITS), .ASID_W(ASID_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .mode64(mode64),
    .wrEn(wrEn), .wrIdx(wrIdx), .wrMaskField(wrMaskField), .wrVpn2(wrVpn2),
    .wrRegion(wrRegion), .wrAsid(wrAsid), .wrGlobal(wrGlobal),
    .wrPfn0(wrPfn0), .wrBits0({wrUncached0, wrDirty0, wrValid0}),
    .wrPfn1(wrPfn1), .wrBits1({wrUncached1, wrDirty1, wrValid1}),
    .wrMaskBad(wrMaskBad),
    .prEn(prEn), .prVpn2(prVpn2), .prRegion(prRegion), .prAsid(prAsid),
    .prDone(prDone), .prResult(prResult),
    .xlEn(xlEn), .xlVa(xlVa), .xlAsid(xlAsid), .xlStore(xlStore), .strb(strb),
    .addrErr(addrErr), .anyHit(anyHit), .selValid(selValid), .selDirty(selDirty),
    .xlDone(xlDone), .xlExc(xlExc), .xlPa(xlPa), .xlUncached(xlUncached),
    .xlMulti(xlMulti), .badVaddr(badVaddr)
  );

endmodule

// File: tb/pair_tlb_test.sv
module pair_tlb_test;

  localparam int CLK_PERIOD = 10;
  localparam int N = 8;
  localparam int VAB = 40;
  localparam int PAB = 36;

  logic clk = 1'b0, rstN = 1'b0, mode64 = 1'b1;
  logic wrEn = 1'b0; logic [2:0] wrIdx = '0; logic [11:0] wrMaskField = '0;
  logic [26:0] wrVpn2 = '0; logic [1:0] wrRegion = '0; logic [7:0] wrAsid = '0;
  logic wrGlobal = 1'b0;
  logic [23:0] wrPfn0 = '0, wrPfn1 = '0;
  logic wrValid0 = 1'b0, wrDirty0 = 1'b0, wrUncached0 = 1'b0;
  logic wrValid1 = 1'b0, wrDirty1 = 1'b0, wrUncached1 = 1'b0;
  logic wrMaskBad;
  logic prEn = 1'b0; logic [26:0] prVpn2 = '0; logic [1:0] prRegion = '0; logic [7:0] prAsid = '0;
  logic prDone; logic [3:0] prResult;
  logic xlEn = 1'b0; logic [63:0] xlVa = '0; logic [7:0] xlAsid = '0; logic xlStore = 1'b0;
  logic xlDone; logic [2:0] xlExc; logic [35:0] xlPa; logic xlUncached, xlMulti;
  logic [63:0] badVaddr;

  int checks = 0, failures = 0;
  bit finished = 1'b0;

  // reference entries
  int          mSz  [N];
  logic [26:0] mVpn [N];
  logic [1:0]  mRgn [N];
  logic [7:0]  mAsid[N];
  logic        mG   [N];
  logic [23:0] mPfn [N][2];
  logic        mV[N][2], mD[N][2], mUc[N][2];
  logic [63:0] expBad = '0;

  pair_tlb #(.NUM_ENTRIES(N), .VA_BITS(VAB), .PA_BITS(PAB), .ASID_W(8)) uut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic bit entryMatch(input int i, input logic [26:0] vpn,
                                    input logic [1:0] rgn, input logic [7:0] asid);
    return (((vpn ^ mVpn[i]) >> (2 * mSz[i])) == 27'd0)
           && (mG[i] || mAsid[i] == asid)
           && (!mode64 || mRgn[i] == rgn);
  endfunction

  function automatic int modelProbe(input logic [26:0] vpn, input logic [1:0] rgn,
                                    input logic [7:0] asid);
    for (int i = 0; i < N; i++) if (entryMatch(i, vpn, rgn, asid)) return i + 1;
    return 0;
  endfunction

  function automatic void modelXl(input logic [63:0] va, input logic [7:0] asid,
                                  input logic st, output logic [2:0] exc,
                                  output logic [35:0] pa, output logic uc,
                                  output logic mul);
    int found = -1; int cnt = 0; int pb; int h;
    logic [35:0] base;
    exc = 3'd0; pa = '0; uc = 1'b0; mul = 1'b0;
    if (mode64 && va[61:40] != 22'd0) begin exc = 3'd4; return; end
    for (int i = 0; i < N; i++) begin
      if (entryMatch(i, va[39:13], va[63:62], asid)) begin
        cnt++;
        if (found < 0) found = i;
      end
    end
    mul = cnt > 1;
    if (found < 0) begin exc = 3'd1; return; end
    pb = 12 + 2 * mSz[found];
    h = int'(va[pb]);
    if (!mV[found][h]) begin exc = 3'd2; return; end
    if (st && !mD[found][h]) begin exc = 3'd3; return; end
    base = {mPfn[found][h], 12'h000};
    pa = ((base >> pb) << pb) | (va[35:0] & ((36'd1 << pb) - 36'd1));
    uc = mUc[found][h];
  endfunction

  task automatic writeEntry(input int idx, input logic [11:0] mf, input logic [26:0] vpn,
                            input logic [1:0] rgn, input logic [7:0] asid, input logic g,
                            input logic [23:0] p0, input logic [2:0] b0,
                            input logic [23:0] p1, input logic [2:0] b1);
    int sz = 0; bit bad = 1'b1;
    for (int s = 0; s < 7; s++) if (mf == 12'((1 << (2 * s)) - 1)) begin sz = s; bad = 1'b0; end
    wrEn = 1'b1; wrIdx = 3'(idx); wrMaskField = mf; wrVpn2 = vpn; wrRegion = rgn;
    wrAsid = asid; wrGlobal = g; wrPfn0 = p0; wrPfn1 = p1;
    {wrUncached0, wrDirty0, wrValid0} = b0; {wrUncached1, wrDirty1, wrValid1} = b1;
    #1;
    chk(wrMaskBad == bad, "R2", "mask flag", 64'(wrMaskBad), 64'(bad));
    @(posedge clk); @(negedge clk);
    wrEn = 1'b0;
    mSz[idx] = sz; mVpn[idx] = vpn; mRgn[idx] = rgn; mAsid[idx] = asid; mG[idx] = g;
    mPfn[idx][0] = p0; mPfn[idx][1] = p1;
    {mUc[idx][0], mD[idx][0], mV[idx][0]} = b0;
    {mUc[idx][1], mD[idx][1], mV[idx][1]} = b1;
  endtask

  task automatic xl(input logic [63:0] va, input logic [7:0] asid, input logic st,
                    input string req);
    logic [2:0] e; logic [35:0] p; logic u, m;
    modelXl(va, asid, st, e, p, u, m);
    if (e != 3'd0) expBad = va;
    xlEn = 1'b1; xlVa = va; xlAsid = asid; xlStore = st;
    @(posedge clk); @(negedge clk);
    xlEn = 1'b0;
    chk(xlDone && xlExc == e && xlPa == p && xlUncached == u && xlMulti == m, req,
        "translate {done,exc,uc,multi,pa}",
        {21'd0, xlDone, xlExc, xlUncached, xlMulti, xlPa},
        {21'd0, 1'b1, e, u, m, p});
    chk(badVaddr == expBad, "R9", "bad address", badVaddr, expBad);
  endtask

  task automatic probe(input logic [26:0] vpn, input logic [1:0] rgn,
                       input logic [7:0] asid, input string req);
    int exp = modelProbe(vpn, rgn, asid);
    prEn = 1'b1; prVpn2 = vpn; prRegion = rgn; prAsid = asid;
    @(posedge clk); @(negedge clk);
    prEn = 1'b0;
    chk(prDone && prResult == 4'(exp), req, "probe {done,result}",
        {59'd0, prDone, prResult}, {59'd0, 1'b1, 4'(exp)});
  endtask

  function automatic logic [63:0] mkVa(input logic [1:0] rgn, input logic [26:0] vpn,
                                       input logic [12:0] off);
    return {rgn, 22'd0, vpn, off};
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < N; i++) begin
      mSz[i] = 0; mVpn[i] = '0; mRgn[i] = '0; mAsid[i] = '0; mG[i] = 1'b0;
      for (int h = 0; h < 2; h++) begin
        mPfn[i][h] = '0; mV[i][h] = 1'b0; mD[i][h] = 1'b0; mUc[i][h] = 1'b0;
      end
    end
    void'($urandom(32'h5EED));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk(!xlDone && xlExc == 3'd0 && xlPa == '0 && !xlMulti && !prDone && prResult == '0
        && badVaddr == '0, "R1", "reset outputs",
        {24'd0, xlDone, xlExc, xlMulti, prDone, prResult, xlPa}, 64'd0);
    xl(mkVa(2'd0, 27'h10000, 13'h0), 8'd5, 1'b0, "R1");
    probe(27'h10000, 2'd0, 8'd5, "R1");
    // R13: no request, no done
    chk(!xlDone, "R13", "done after idle", 64'(xlDone), 64'd0);

    // directed entries
    writeEntry(0, 12'h000, 27'h100, 2'd0, 8'd3, 1'b0, 24'hAAAAA, 3'b011, 24'h55555, 3'b101);
    xl(mkVa(2'd0, 27'h100, 13'h0123), 8'd3, 1'b0, "R8");
    xl(mkVa(2'd0, 27'h100, 13'h1456), 8'd3, 1'b1, "R7");
    xl(mkVa(2'd0, 27'h100, 13'h1456), 8'd3, 1'b0, "R8");
    xl(mkVa(2'd0, 27'h100, 13'h0123), 8'd4, 1'b0, "R4");
    writeEntry(1, 12'hFFF, 27'h4000, 2'd0, 8'd9, 1'b1, 24'h001000, 3'b011, 24'h002000, 3'b011);
    writeEntry(1, 12'hFFF, 27'h4000, 2'd0, 8'd9, 1'b1, 24'h001000, 3'b010, 24'h002000, 3'b011);
    xl(mkVa(2'd0, 27'h4000, 13'h0345), 8'h77, 1'b0, "R6");
    xl(64'h0000_0000_09AB_CDEF, 8'h77, 1'b1, "R3");
    writeEntry(2, 12'h007, 27'h300, 2'd0, 8'd3, 1'b0, 24'h000011, 3'b000, 24'h000012, 3'b011);
    xl(mkVa(2'd0, 27'h300, 13'h1010), 8'd3, 1'b0, "R2");
    xl(mkVa(2'd0, 27'h301, 13'h0010), 8'd3, 1'b0, "R2");
    writeEntry(3, 12'h00F, 27'h500, 2'd0, 8'd3, 1'b0, 24'h000040, 3'b011, 24'h000080, 3'b111);
    xl(mkVa(2'd0, 27'h503, 13'h1678), 8'd3, 1'b0, "R3");
    xl(mkVa(2'd0, 27'h508, 13'h0678), 8'd3, 1'b0, "R3");
    xl(mkVa(2'd0, 27'h504, 13'h0678), 8'd3, 1'b0, "R5");
    xl(mkVa(2'd2, 27'h500, 13'h0678), 8'd3, 1'b0, "R5");
    mode64 = 1'b0;
    xl(mkVa(2'd2, 27'h500, 13'h0678), 8'd3, 1'b0, "R5");
    xl(mkVa(2'd0, 27'h500, 13'h0678) | 64'h0000_2000_0000_0000, 8'd3, 1'b0, "R10");
    mode64 = 1'b1;
    xl(mkVa(2'd0, 27'h500, 13'h0678) | 64'h0000_2000_0000_0000, 8'd3, 1'b0, "R10");
    xl(mkVa(2'd0, 27'h500, 13'h0678) | 64'h2000_0000_0000_0000, 8'd3, 1'b1, "R10");
    probe(27'h501, 2'd0, 8'd3, "R11");
    probe(27'h777, 2'd0, 8'd3, "R11");
    writeEntry(5, 12'h00F, 27'h500, 2'd0, 8'd3, 1'b0, 24'h0000C0, 3'b011, 24'h0000C0, 3'b011);
    writeEntry(4, 12'h000, 27'h502, 2'd0, 8'd0, 1'b1, 24'h0000F0, 3'b011, 24'h0000F0, 3'b011);
    xl(mkVa(2'd0, 27'h502, 13'h0678), 8'd3, 1'b0, "R12");
    probe(27'h502, 2'd0, 8'd3, "R12");
    xl(mkVa(2'd0, 27'h502, 13'h0678), 8'd6, 1'b0, "R12");
    @(negedge clk);
    chk(!xlDone, "R13", "done drops", 64'(xlDone), 64'd0);

    // random phase
    for (int i = 0; i < N; i++) begin
      int s = int'($urandom % 7);
      writeEntry(i, 12'((1 << (2 * s)) - 1), 27'($urandom), 2'($urandom), 8'($urandom % 4),
                 ($urandom % 4) == 0, 24'($urandom), 3'($urandom | 1), 24'($urandom),
                 3'($urandom));
    end
    for (int k = 0; k < 400; k++) begin
      int e = int'($urandom % N);
      logic [26:0] vpn = mVpn[e] ^ (27'($urandom) & 27'((1 << (2 * mSz[e])) - 1));
      logic [1:0]  rgn = (($urandom % 8) == 0) ? 2'($urandom) : mRgn[e];
      logic [7:0]  asid = (($urandom % 8) == 0) ? 8'($urandom) : mAsid[e];
      logic [63:0] va;
      if (($urandom % 10) == 0) vpn = 27'($urandom);
      va = mkVa(rgn, vpn, 13'($urandom));
      if (($urandom % 16) == 0) va[40 + int'($urandom % 22)] = 1'b1;
      mode64 = ($urandom % 8) != 0;
      xl(va, asid, 1'($urandom), "R8");
      probe(vpn, rgn, asid, "R11");
    end

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule